// File: doc/BRIEF.md
# GPIO Port with Peripheral Override

This block controls an eight-pin general-purpose I/O port. Software sets each pin's direction and output level through two byte-wide registers on a simple register bus. On-chip peripherals can take over the upper pins. A CAN controller, two I2C controllers and two chip-select lines each have an enable that claims specific pins. While a peripheral is enabled, it fixes the direction, drive mode and output value of its pins. The software registers are left untouched throughout.

When a peripheral is disabled, its pins go back to the software direction and data bits at once. Software can therefore set a safe fallback direction before it switches a peripheral on or off. The pad cell, pull devices and peripheral logic are outside the block. The block produces a per-pin output enable, output value and open-drain flag for the pad ring.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset, both the direction register and the data register read 0. With no peripheral enabled, every pin then has output enable 0 and open-drain flag 0.
- R2: A bus write to address 0x02 (the direction register) stores the write data on the next rising clock edge. Reads at 0x02 return the stored value combinationally. There is no mode or write-once restriction.
- R3: A bus write to address 0x00 (the data register) stores the write data on the next edge, and reads at 0x00 return it. A write to any other address changes neither register, and reads at any other address return 0.
- R4: For a pin with no active override, the output enable equals its direction bit (1 = output, 0 = input), the output value equals its data bit, and the open-drain flag is 0.
- R5: While the CAN enable is high and the first I2C enable is low, pin 7 (CAN transmit) is an output carrying the CAN transmit value. Pin 6 (CAN receive) is an input with output value 0. Both pins have open-drain 0.
- R6: While the first I2C enable is high, pins 7 (clock) and 6 (data) are open-drain, whatever the CAN enable is. Each such pin has output enable equal to the inverse of its I2C output bit and output value equal to that bit.
- R7: While the second I2C enable is high, pins 5 (clock) and 4 (data) are open-drain in the same way, whatever the chip-select enables are.
- R8: While the second I2C enable is low, an enabled chip select 2 makes pin 5 a push-pull output carrying the chip-select-2 value. An enabled chip select 0 does the same for pin 4.
- R9: Peripheral overrides never change the stored direction or data bits. Reads return the software-written values, and a pin reverts to them in the same cycle its peripheral is disabled.
- R10: Pins 3 to 0 follow only their direction and data bits, whatever the peripheral enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from busAddr |
| canEn | input | 1 | CAN controller owns pins 7 and 6 |
| canTxd | input | 1 | CAN transmit value for pin 7 |
| i2cAEn | input | 1 | First I2C controller owns pins 7 and 6 |
| i2cASclOut | input | 1 | First I2C clock output bit (pin 7) |
| i2cASdaOut | input | 1 | First I2C data output bit (pin 6) |
| i2cBEn | input | 1 | Second I2C controller owns pins 5 and 4 |
| i2cBSclOut | input | 1 | Second I2C clock output bit (pin 5) |
| i2cBSdaOut | input | 1 | Second I2C data output bit (pin 4) |
| cs2En | input | 1 | Chip select 2 owns pin 5 |
| cs2Out | input | 1 | Chip select 2 level |
| cs0En | input | 1 | Chip select 0 owns pin 4 |
| cs0Out | input | 1 | Chip select 0 level |
| padOe | output | 8 | Per-pin output enable |
| padOut | output | 8 | Per-pin output value |
| padOd | output | 8 | Per-pin open-drain flag |

## Verification
The hardest situation to reach is a stacked override: two owners claim the same pin while software writes opposing direction bits underneath. The output must follow the higher-priority owner, and the stored bits must still read back unchanged. The random stimulus draws all twelve peripheral inputs at once with every step, so CAN-plus-I2C and chip-select-plus-I2C overlaps arise often. Register writes land in the same steps. Directed steps then drop every enable at once after a write made under override, which checks that the pins revert to the latest software values in the same cycle.

// File: rtl/gpio_ovr_pkg.sv
`timescale 1ns/1ps
package gpio_ovr_pkg;

  // Strobes from the bus decoder to the register datapath
  typedef struct packed {
    logic wrDir;
    logic wrData;
    logic rdDir;
    logic rdData;
  } busStrobe_t;

  // Per-pin takeover request built from the peripheral enables
  typedef struct packed {
    logic odReq;   // open-drain ownership
    logic odVal;   // open-drain data bit
    logic outReq;  // forced push-pull output
    logic outVal;  // forced output value
    logic inReq;   // forced input
  } pinReq_t;

endpackage

// File: rtl/gpio_ovr_ctrl.sv
`timescale 1ns/1ps
module gpio_ovr_ctrl
  import gpio_ovr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_ADDR = 0,
  parameter int DIR_ADDR  = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output busStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] DataAddrC = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] DirAddrC  = ADDR_W'(DIR_ADDR);

  logic hitDir;
  logic hitData;

  assign hitDir  = (busAddr == DirAddrC);
  assign hitData = (busAddr == DataAddrC);

  always_comb begin
    strobe        = '0;
    strobe.rdDir  = hitDir;
    strobe.rdData = hitData;
    strobe.wrDir  = hitDir  & busWrEn;
    strobe.wrData = hitData & busWrEn;
  end
endmodule

// File: rtl/gpio_ovr_regs.sv
`timescale 1ns/1ps
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  busStrobe_t          strobe,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  output logic [NUM_PINS-1:0] dirQ,
  output logic [NUM_PINS-1:0] dataQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '0;
    end else if (strobe.wrDir) begin
      dirQ <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
    end else if (strobe.wrData) begin
      dataQ <= busWrData;
    end
  end

  always_comb begin
    busRdData = '0;
    if (strobe.rdDir) begin
      busRdData = dirQ;
    end else if (strobe.rdData) begin
      busRdData = dataQ;
    end
  end
endmodule

// File: rtl/gpio_ovr_map.sv
`timescale 1ns/1ps
module gpio_ovr_map
  import gpio_ovr_pkg::*;
#(
  parameter int NUM_PINS   = 8,
  parameter int PIN_CANTX  = 7,
  parameter int PIN_CANRX  = 6,
  parameter int PIN_ASCL   = 7,
  parameter int PIN_ASDA   = 6,
  parameter int PIN_BSCL   = 5,
  parameter int PIN_BSDA   = 4,
  parameter int PIN_CS2    = 5,
  parameter int PIN_CS0    = 4
) (
  input  logic canEn,
  input  logic canTxd,
  input  logic i2cAEn,
  input  logic i2cASclOut,
  input  logic i2cASdaOut,
  input  logic i2cBEn,
  input  logic i2cBSclOut,
  input  logic i2cBSdaOut,
  input  logic cs2En,
  input  logic cs2Out,
  input  logic cs0En,
  input  logic cs0Out,
  output pinReq_t [NUM_PINS-1:0] req
);
  always_comb begin
    req = '0;
    // CAN: transmit pin driven, receive pin held as input
    req[PIN_CANTX].outReq = canEn;
    req[PIN_CANTX].outVal = canTxd;
    req[PIN_CANRX].inReq  = canEn;
    // Chip selects: push-pull outputs
    req[PIN_CS2].outReq   = cs2En;
    req[PIN_CS2].outVal   = cs2Out;
    req[PIN_CS0].outReq   = cs0En;
    req[PIN_CS0].outVal   = cs0Out;
    // I2C controllers: open-drain pairs
    req[PIN_ASCL].odReq   = i2cAEn;
    req[PIN_ASCL].odVal   = i2cASclOut;
    req[PIN_ASDA].odReq   = i2cAEn;
    req[PIN_ASDA].odVal   = i2cASdaOut;
    req[PIN_BSCL].odReq   = i2cBEn;
    req[PIN_BSCL].odVal   = i2cBSclOut;
    req[PIN_BSDA].odReq   = i2cBEn;
    req[PIN_BSDA].odVal   = i2cBSdaOut;
  end
endmodule

// File: rtl/gpio_ovr_resolve.sv
`timescale 1ns/1ps
module gpio_ovr_resolve
  import gpio_ovr_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  pinReq_t [NUM_PINS-1:0] req,
  input  logic    [NUM_PINS-1:0] dirQ,
  input  logic    [NUM_PINS-1:0] dataQ,
  output logic    [NUM_PINS-1:0] padOe,
  output logic    [NUM_PINS-1:0] padOut,
  output logic    [NUM_PINS-1:0] padOd
);
  // Priority per pin: open-drain, forced output, forced input, software
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pinReq_t r;
    assign r = req[p];
    assign padOd[p]  = r.odReq;
    assign padOe[p]  = r.odReq  ? ~r.odVal :
                       r.outReq ? 1'b1     :
                       r.inReq  ? 1'b0     : dirQ[p];
    assign padOut[p] = r.odReq  ? r.odVal  :
                       r.outReq ? r.outVal :
                       r.inReq  ? 1'b0     : dataQ[p];
  end
endmodule

// File: rtl/gpio_ovr_port.sv
`timescale 1ns/1ps
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int NUM_PINS  = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_ADDR = 0,
  parameter int DIR_ADDR  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic                canEn,
  input  logic                canTxd,
  input  logic                i2cAEn,
  input  logic                i2cASclOut,
  input  logic                i2cASdaOut,
  input  logic                i2cBEn,
  input  logic                i2cBSclOut,
  input  logic                i2cBSdaOut,
  input  logic                cs2En,
  input  logic                cs2Out,
  input  logic                cs0En,
  input  logic                cs0Out,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOd
);
  busStrobe_t                strobe;
  logic    [NUM_PINS-1:0]    dirQ;
  logic    [NUM_PINS-1:0]    dataQ;
  pinReq_t [NUM_PINS-1:0]    req;

  gpio_ovr_ctrl #(
    .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
  ) ctrl_i (
    .busAddr(busAddr), .busWrEn(busWrEn), .strobe(strobe)
  );

  gpio_ovr_regs #(.NUM_PINS(NUM_PINS)) regs_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWrData(busWrData),
    .busRdData(busRdData), .dirQ(dirQ), .dataQ(dataQ)
  );

  gpio_ovr_map #(.NUM_PINS(NUM_PINS)) map_i (
    .canEn(canEn), .canTxd(canTxd),
    .i2cAEn(i2cAEn), .i2cASclOut(i2cASclOut), .i2cASdaOut(i2cASdaOut),
    .i2cBEn(i2cBEn), .i2cBSclOut(i2cBSclOut), .i2cBSdaOut(i2cBSdaOut),
    .cs2En(cs2En), .cs2Out(cs2Out), .cs0En(cs0En), .cs0Out(cs0Out),
    .req(req)
  );

  gpio_ovr_resolve #(.NUM_PINS(NUM_PINS)) resolve_i (
    .req(req), .dirQ(dirQ), .dataQ(dataQ),
    .padOe(padOe), .padOut(padOut), .padOd(padOd)
  );
endmodule

// File: rtl/gpio_ovr_port_chk.sv
`timescale 1ns/1ps
module gpio_ovr_port_chk #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 8,
  parameter int DIR_ADDR = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWrEn,
  input logic [NUM_PINS-1:0] busWrData,
  input logic [NUM_PINS-1:0] dirQ,
  input logic                canEn,
  input logic                canTxd,
  input logic                i2cAEn,
  input logic                i2cASclOut,
  input logic                i2cBEn,
  input logic                cs2En,
  input logic                cs2Out,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOd
);
  logic dirWr;
  assign dirWr = busWrEn && (busAddr == ADDR_W'(DIR_ADDR));

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    dirWr |=> dirQ == $past(busWrData)); // R2
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !dirWr |=> $stable(dirQ)); // R9
  AST_LOW_PINS: assert property (@(posedge clk) disable iff (!rstN)
    padOe[3:0] == dirQ[3:0] && padOd[3:0] == 4'b0); // R10
  AST_CAN_PINS: assert property (@(posedge clk) disable iff (!rstN)
    canEn && !i2cAEn |-> padOe[7] && padOut[7] == canTxd && !padOe[6]); // R5
  AST_I2CA_OD: assert property (@(posedge clk) disable iff (!rstN)
    i2cAEn |-> padOd[7:6] == 2'b11 && padOe[7] == !i2cASclOut); // R6
  AST_I2CB_OD: assert property (@(posedge clk) disable iff (!rstN)
    i2cBEn |-> padOd[5:4] == 2'b11); // R7
  AST_CS2_OUT: assert property (@(posedge clk) disable iff (!rstN)
    cs2En && !i2cBEn |-> padOe[5] && padOut[5] == cs2Out && !padOd[5]); // R8
  AST_PIN5_SW: assert property (@(posedge clk) disable iff (!rstN)
    !cs2En && !i2cBEn |-> padOe[5] == dirQ[5] && !padOd[5]); // R4
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR)
) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .dirQ(dirQ), .canEn(canEn), .canTxd(canTxd),
  .i2cAEn(i2cAEn), .i2cASclOut(i2cASclOut), .i2cBEn(i2cBEn),
  .cs2En(cs2En), .cs2Out(cs2Out), .padOe(padOe), .padOut(padOut),
  .padOd(padOd)
);

// File: tb/gpio_ovr_port_tb_top.sv
`timescale 1ns/1ps
module gpio_ovr_port_tb_top;
  localparam logic [7:0] DATA_A = 8'h00;
  localparam logic [7:0] DIR_A  = 8'h02;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic canEn, canTxd, i2cAEn, i2cASclOut, i2cASdaOut;
  logic i2cBEn, i2cBSclOut, i2cBSdaOut, cs2En, cs2Out, cs0En, cs0Out;
  logic [7:0] padOe, padOut, padOd;

  int checks = 0;
  int failures = 0;
  logic [7:0] dirM = '0;
  logic [7:0] dataM = '0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_ovr_port dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .canEn(canEn), .canTxd(canTxd), .i2cAEn(i2cAEn),
    .i2cASclOut(i2cASclOut), .i2cASdaOut(i2cASdaOut), .i2cBEn(i2cBEn),
    .i2cBSclOut(i2cBSclOut), .i2cBSdaOut(i2cBSdaOut), .cs2En(cs2En),
    .cs2Out(cs2Out), .cs0En(cs0En), .cs0Out(cs0Out),
    .padOe(padOe), .padOut(padOut), .padOd(padOd)
  );

  // Peripheral vector {canEn,canTxd,i2cAEn,ascl,asda,i2cBEn,bscl,bsda,cs2En,cs2Out,cs0En,cs0Out}
  task automatic setPer(input logic [11:0] p);
    {canEn, canTxd, i2cAEn, i2cASclOut, i2cASdaOut, i2cBEn,
     i2cBSclOut, i2cBSdaOut, cs2En, cs2Out, cs0En, cs0Out} = p;
  endtask

  // Expected {oe, out, od} from the requirements
  function automatic logic [23:0] expPads(input logic [7:0] dir, input logic [7:0] dat,
                                          input logic [11:0] p);
    logic [7:0] oe, ov, od;
    oe = dir; ov = dat; od = '0;
    if (p[11]) begin oe[7] = 1'b1; ov[7] = p[10]; oe[6] = 1'b0; ov[6] = 1'b0; end
    if (p[9]) begin
      od[7] = 1'b1; oe[7] = !p[8]; ov[7] = p[8];
      od[6] = 1'b1; oe[6] = !p[7]; ov[6] = p[7];
    end
    if (p[3]) begin oe[5] = 1'b1; ov[5] = p[2]; end
    if (p[1]) begin oe[4] = 1'b1; ov[4] = p[0]; end
    if (p[6]) begin
      od[5] = 1'b1; oe[5] = !p[5]; ov[5] = p[5];
      od[4] = 1'b1; oe[4] = !p[4]; ov[4] = p[4];
    end
    return {oe, ov, od};
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle, then pad and readback checks before the next falling edge
  task automatic step(input logic wr, input logic [7:0] addr, input logic [7:0] wd,
                      input logic [11:0] p, input string padTag, input string rdTag);
    @(negedge clk);
    setPer(p);
    busWrEn = wr; busAddr = addr; busWrData = wd;
    @(posedge clk);
    if (wr && addr == DIR_A) dirM = wd;
    else if (wr && addr == DATA_A) dataM = wd;
    #0.5 busWrEn = 1'b0;
    check(padTag, {padOe, padOut, padOd}, expPads(dirM, dataM, p));
    busAddr = DIR_A;
    #0.5 check({rdTag, " dir"}, {16'h0, busRdData}, {16'h0, dirM});
    busAddr = DATA_A;
    #0.5 check({rdTag, " data"}, {16'h0, busRdData}, {16'h0, dataM});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    setPer('0);
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #0.5;
    // R1 reset state
    check("R1 pads", {padOe, padOut, padOd}, 24'h0);
    busAddr = DIR_A;  #0.2 check("R1 dir",  {16'h0, busRdData}, 24'h0);
    busAddr = DATA_A; #0.2 check("R1 data", {16'h0, busRdData}, 24'h0);
    busAddr = 8'h55;  #0.2 check("R3 unmapped read", {16'h0, busRdData}, 24'h0);

    step(1, DIR_A,  8'hA5, '0, "R4 dir write", "R2");
    step(1, DATA_A, 8'h3C, '0, "R4 data write", "R3");
    step(1, 8'h07,  8'hFF, '0, "R4 stray write", "R3");
    step(1, DIR_A,  8'h00, 12'b1100_0000_0000, "R5 can tx1", "R9");
    step(0, DIR_A,  8'h00, 12'b1000_0000_0000, "R5 can tx0", "R9");
    step(1, DIR_A,  8'hFF, 12'b1110_1000_0000, "R6 i2cA over can", "R9");
    step(0, DIR_A,  8'h00, 12'b0011_0000_0000, "R6 i2cA scl1 sda0", "R9");
    step(1, DATA_A, 8'h0F, 12'b0000_0101_1111, "R7 i2cB over cs", "R9");
    step(0, DIR_A,  8'h00, 12'b0000_0000_1110, "R8 cs2 high cs0 low", "R9");
    step(0, DIR_A,  8'h00, 12'b0000_0000_0011, "R8 cs0 only", "R9");
    step(1, DIR_A,  8'h5A, 12'b1111_1111_1111, "R10 all enabled", "R2");
    step(0, DIR_A,  8'h00, 12'b0000_0000_0000, "R9 revert", "R9");

    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      logic [1:0] sel;
      sel = 2'($urandom);
      a = (sel == 0) ? DATA_A : (sel == 3) ? 8'($urandom) : DIR_A;
      step(1'($urandom), a, 8'($urandom), 12'($urandom),
           "R4/R5/R6/R7/R8/R10 random", "R2/R3/R9 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule